// File: doc/BRIEF.md
# Rotate Unit with Flag Generation

This block rotates an 8-bit operand by one position and produces the condition flags that go with the result. Three kinds of rotate are offered. Two move bits toward the most significant end: one wraps the old top bit into bit 0, and the other feeds bit 0 from the carry input. The third moves bits toward the least significant end and wraps the old bit 0 into bit 7. The bit that drops out of the operand becomes the new carry. The other flags describe the result: its sign, whether it is zero, and whether its parity is even. The half-carry and subtract flags are always cleared.

A datapath presents the operand, the carry input and the 3-bit select taken from opcode bits 5..3, then pulses the strobe. On that rising edge the result byte and the flag byte are registered. An unsupported select passes the operand through unchanged and leaves the flag register as it was. An active-low asynchronous reset clears both registers.

Top module: `rot_unit`

## Requirements
- R1: With select 000, a strobed edge loads res_o with the operand moved one place toward bit 7, and the old bit 7 in bit 0.
- R2: With select 010, a strobed edge loads res_o with the operand moved one place toward bit 7, and cin_i in bit 0.
- R3: With select 001, a strobed edge loads res_o with the operand moved one place toward bit 0, and the old bit 0 in bit 7.
- R4: For a supported select, flag bit 0 (carry) takes operand bit 7 for selects 000 and 010, and operand bit 0 for select 001.
- R5: For a supported select, flag bit 7 (sign) equals result bit 7, and flag bit 6 (zero) is 1 exactly when the result is 0x00.
- R6: Flag bit 4 (half-carry), flag bit 1 (subtract) and the unused flag bits 5 and 3 always read 0.
- R7: For a supported select, flag bit 2 (parity) is 1 exactly when the result has an even number of 1 bits.
- R8: A strobed edge with any select from 011 to 111 loads res_o with the operand unchanged and leaves flags_o unchanged.
- R9: An edge with stb_i low changes neither res_o nor flags_o.
- R10: While rst_ni is low, res_o and flags_o both read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Capture strobe |
| sel_i | input | 3 | Rotate select (opcode bits 5..3) |
| opnd_i | input | 8 | Operand byte |
| cin_i | input | 1 | Carry input for the through-carry rotate |
| res_o | output | 8 | Registered result byte |
| flags_o | output | 8 | Registered flags: S,Z,0,H,0,P,N,C from bit 7 down to bit 0 |

## Verification
The assertions assume that stb_i, sel_i, opnd_i and cin_i are known and do not change at a rising clock edge. They also assume that reset is applied before the first strobe, so that the flag register has a defined value to hold when an unsupported select arrives. The stimulus changes every input only on the falling edge, and it asserts reset before the first strobe and once more in the middle of the run. The select sweep covers all eight codes, and the operands include 0x00, 0x80, 0x01, 0xFF and values of both parities.

// File: rtl/rot_pkg.sv
`timescale 1ns/1ps
package rot_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned MSB    = DATA_W - 1;
  localparam int unsigned SEL_W  = 3;

  typedef logic [DATA_W-1:0] dword_t;
  typedef logic [SEL_W-1:0]  sel_t;

  // select codes (opcode bits 5..3)
  localparam sel_t SEL_ROL_CIRC = 3'b000;
  localparam sel_t SEL_ROR_CIRC = 3'b001;
  localparam sel_t SEL_ROL_CARRY = 3'b010;

  // flag byte bit positions
  localparam int unsigned FL_C = 0;
  localparam int unsigned FL_N = 1;
  localparam int unsigned FL_P = 2;
  localparam int unsigned FL_H = 4;
  localparam int unsigned FL_Z = 6;
  localparam int unsigned FL_S = 7;
endpackage

// File: rtl/rot_shifter.sv
`timescale 1ns/1ps
module rot_shifter
  import rot_pkg::*;
(
  input  dword_t opnd_i,
  input  logic   cin_i,
  input  sel_t   sel_i,
  output dword_t res_o,
  output logic   cout_o,
  output logic   valid_o
);
  dword_t lft, rgt;
  logic   fill_l;

  assign fill_l = (sel_i == SEL_ROL_CARRY) ? cin_i : opnd_i[MSB];

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign lft[i] = fill_l;
      assign rgt[i] = opnd_i[i+1];
    end else if (i == MSB) begin : g_msb
      assign lft[i] = opnd_i[i-1];
      assign rgt[i] = opnd_i[0];
    end else begin : g_mid
      assign lft[i] = opnd_i[i-1];
      assign rgt[i] = opnd_i[i+1];
    end
  end

  always_comb begin
    valid_o = 1'b1;
    res_o   = lft;
    cout_o  = opnd_i[MSB];
    unique case (sel_i)
      SEL_ROL_CIRC, SEL_ROL_CARRY: begin
        res_o  = lft;
        cout_o = opnd_i[MSB];
      end
      SEL_ROR_CIRC: begin
        res_o  = rgt;
        cout_o = opnd_i[0];
      end
      default: begin
        valid_o = 1'b0;
        res_o   = opnd_i;
        cout_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rot_flags.sv
`timescale 1ns/1ps
module rot_flags
  import rot_pkg::*;
(
  input  dword_t res_i,
  input  logic   cout_i,
  output dword_t flags_o
);
  always_comb begin
    flags_o       = '0;
    flags_o[FL_S] = res_i[MSB];
    flags_o[FL_Z] = (res_i == '0);
    flags_o[FL_H] = 1'b0;
    flags_o[FL_P] = ~^res_i;  // even parity
    flags_o[FL_N] = 1'b0;
    flags_o[FL_C] = cout_i;
  end
endmodule

// File: rtl/rot_unit.sv
`timescale 1ns/1ps
module rot_unit
  import rot_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] flags_o
);
  dword_t nxt_res, nxt_flags, res_q, flags_q;
  logic   cout, op_valid;

  rot_shifter u_shift (
    .opnd_i (opnd_i),
    .cin_i  (cin_i),
    .sel_i  (sel_i),
    .res_o  (nxt_res),
    .cout_o (cout),
    .valid_o(op_valid)
  );

  rot_flags u_flags (
    .res_i  (nxt_res),
    .cout_i (cout),
    .flags_o(nxt_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (stb_i) begin
      res_q <= nxt_res;
      if (op_valid) flags_q <= nxt_flags;  // unsupported select keeps flags
    end
  end

  assign res_o   = res_q;
  assign flags_o = flags_q;
endmodule

// File: rtl/rot_unit_chk.sv
`timescale 1ns/1ps
module rot_unit_chk
  import rot_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stb_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [DATA_W-1:0] opnd_i,
  input logic              cin_i,
  input logic [DATA_W-1:0] res_o,
  input logic [DATA_W-1:0] flags_o
);
  logic arm_q;  // previous edge was taken out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= 1'b0;
    else         arm_q <= 1'b1;
  end

  logic good_sel;
  assign good_sel = (sel_i == SEL_ROL_CIRC) || (sel_i == SEL_ROR_CIRC) ||
                    (sel_i == SEL_ROL_CARRY);

  a_r1_rol_circ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(sel_i) == SEL_ROL_CIRC
    |-> res_o == {$past(opnd_i[MSB-1:0]), $past(opnd_i[MSB])});

  a_r2_rol_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(sel_i) == SEL_ROL_CARRY
    |-> res_o == {$past(opnd_i[MSB-1:0]), $past(cin_i)});

  a_r3_ror_circ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(sel_i) == SEL_ROR_CIRC
    |-> res_o == {$past(opnd_i[0]), $past(opnd_i[MSB:1])});

  a_r4_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(good_sel)
    |-> flags_o[FL_C] == (($past(sel_i) == SEL_ROR_CIRC) ? $past(opnd_i[0])
                                                         : $past(opnd_i[MSB])));

  a_r5_sign_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(good_sel)
    |-> flags_o[FL_S] == res_o[MSB] && flags_o[FL_Z] == (res_o == '0));

  a_r6_fixed_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FL_H] == 1'b0 && flags_o[FL_N] == 1'b0 && flags_o[5] == 1'b0 &&
    flags_o[3] == 1'b0);

  a_r7_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && $past(good_sel)
    |-> flags_o[FL_P] == ($countones(res_o) % 2 == 0));

  a_r8_bad_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && $past(stb_i) && !$past(good_sel)
    |-> res_o == $past(opnd_i) && $stable(flags_o));

  a_r9_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q && !$past(stb_i) |-> $stable(res_o) && $stable(flags_o));

  a_r10_reset: assert property (@(posedge clk_i)
    !rst_ni |-> res_o == '0 && flags_o == '0);
endmodule

bind rot_unit rot_unit_chk u_chk (.*);

// File: tb/tb_rot_unit.sv
`timescale 1ns/1ps
module tb_rot_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic       stb_i = 1'b0;
  logic [2:0] sel_i = '0;
  logic [7:0] opnd_i = '0;
  logic       cin_i = 1'b0;
  logic [7:0] res_o, flags_o;

  int checks = 0;
  int errors = 0;

  rot_unit dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  typedef struct {
    logic [7:0] res;
    logic [7:0] flg;
    string      tag;
  } exp_t;

  exp_t       q[$];
  exp_t       cur;
  logic [7:0] m_res = '0;
  logic [7:0] m_flg = '0;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, act, exp);
    end
  endtask

  // reference from requirements
  task automatic apply(logic stb, logic [2:0] sel, logic [7:0] op, logic cin, string tag);
    exp_t e;
    logic [7:0] r;
    logic c;
    logic ok;
    @(negedge clk_i);
    stb_i = stb; sel_i = sel; opnd_i = op; cin_i = cin;
    @(posedge clk_i);
    ok = 1'b1;
    case (sel)
      3'b000:  begin r = {op[6:0], op[7]}; c = op[7]; end
      3'b010:  begin r = {op[6:0], cin};   c = op[7]; end
      3'b001:  begin r = {op[0], op[7:1]}; c = op[0]; end
      default: begin r = op; c = 1'b0; ok = 1'b0; end
    endcase
    if (stb) begin
      m_res = r;
      if (ok) m_flg = {r[7], (r == 8'h00), 3'b000, ~^r, 1'b0, c};
    end
    e.res = m_res; e.flg = m_flg; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk_i) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      check(cur.tag, res_o, cur.res, "result");
      check(cur.tag, flags_o, cur.flg, "flags");
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #5 rst_ni = 1'b0;
    @(negedge clk_i);
    check("R10", res_o, 8'h00, "reset result");
    check("R10", flags_o, 8'h00, "reset flags");
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 left circular, R4/R5/R6/R7 flags
    apply(1, 3'b000, 8'h81, 0, "R1/R4/R5/R7");
    apply(1, 3'b000, 8'h00, 1, "R1/R5/R6");
    apply(1, 3'b000, 8'h40, 0, "R1/R5");
    apply(1, 3'b000, 8'hFF, 0, "R1/R7");
    // R2 left through carry
    apply(1, 3'b010, 8'h80, 0, "R2/R4/R5");
    apply(1, 3'b010, 8'h80, 1, "R2/R4");
    apply(1, 3'b010, 8'h55, 1, "R2/R7");
    apply(1, 3'b010, 8'h00, 0, "R2/R5/R6");
    // R3 right circular
    apply(1, 3'b001, 8'h01, 0, "R3/R4/R5");
    apply(1, 3'b001, 8'h02, 1, "R3/R4/R7");
    apply(1, 3'b001, 8'hFE, 0, "R3/R4");
    apply(1, 3'b001, 8'h00, 1, "R3/R5");
    // R8 unsupported selects: flags from last valid op kept
    apply(1, 3'b000, 8'h81, 0, "R1/R4");
    for (int s = 3; s < 8; s++) apply(1, 3'(s), 8'h3C + 8'(s), 1, "R8");
    // R9 strobe low holds both registers
    apply(1, 3'b001, 8'hA7, 0, "R3/R7");
    apply(0, 3'b000, 8'h00, 1, "R9");
    apply(0, 3'b010, 8'hFF, 0, "R9");
    apply(0, 3'b110, 8'h12, 1, "R9");
    drain();

    // R10 reset in the middle of a run
    rst_ni = 1'b0;
    #1;
    check("R10", res_o, 8'h00, "mid reset result");
    check("R10", flags_o, 8'h00, "mid reset flags");
    m_res = '0; m_flg = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(1, 3'b101, 8'h99, 0, "R8/R10");
    apply(1, 3'b010, 8'h7F, 1, "R2/R6");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule